// File: doc/BRIEF.md
# LCD Frame Fetch Sequencer

This block decides, once per display refresh, whether a frame of pixel data can be fetched and where it starts. When the controller is switched on, it first checks the frame buffer addresses, using validity flags from an external range checker. It then optionally loads the palette. On each refresh tick it reads the depth field of the first palette word of the active buffer. From that field it derives the pixel depth and the size of the header that sits in front of the pixels.

Next it confirms that the whole frame fits inside the active buffer. A frame that fits is handed on as a base address, depth, stride and line window. A frame that does not fit raises a sync-error pulse and switches the controller off. Each fetched frame sets a sticky DMA condition bit for its buffer and can raise a DMA interrupt. In dual mode, successive frames alternate between two buffers.

The memory port is a simple request/acknowledge pair. The memory side returns only bits 14:12 of the addressed 16-bit palette word.

Top module: `lcd_fetch_seq`

## Requirements
- R1: The depth field (bits 14:12 of the first palette word) maps 1→2, 2→4, 3→8 and 4..7→16 bits per pixel. A field of 0 skips the frame: no `frame_done`, no `sync_err`, and no condition bit is set.
- R2: When `plm` is not 2, a refresh reads the header at the active buffer top. `frame_base` is then top+0x200 for depth fields 3..7 and top+0x20 for fields 1..2. When `plm` is 2, no read is made, `frame_base` equals top, and the depth field stored from the most recent read is used.
- R3: A `frame_tick` has no effect while `plm` is 1 or while `en_active` is low: no read request and no frame result.
- R4: Let need = header offset + (width × height × bpp)/8, where width is `width_m1`+1 and height is `height_m1`+1. If need exceeds (bottom − top + 2) of the active buffer, or bottom is below top, `sync_err` pulses for one cycle and `en_active` drops. It stays low until `cfg_en` falls and rises again.
- R5: A fetched frame pulses `frame_done`, sets `dma_cond[0]` (buffer 0) or `dma_cond[1]` (buffer 1), and pulses `dma_irq` only if `dma_ie[0]` is 1. `dma_cond` bits are sticky until reset.
- R6: With `dual`=1 the active buffer alternates 0,1,0,... after every fetched frame. With `dual`=0 it stays where it is. It returns to buffer 0 on every rise of `cfg_en`.
- R7: On a rise of `cfg_en`, the block requires `addr_ok[0]` (top 0) and `addr_ok[1]` (bottom 0). In dual mode it also requires `addr_ok[2]` (top 1) and `addr_ok[3]` (bottom 1). If any required flag is 0, `dma_cond[2]` is set, `dma_irq` pulses only if `dma_ie[1]` is 1, and `en_active` stays low.
- R8: After a valid enable with `plm` not 2, one read is issued at `top0` and `pal_done` goes high on its acknowledge. With `plm`=2, no read is made and `pal_done` stays low.
- R9: With `sp_on`=1 and `sp_first_mode`=1, `first_line`=`sp_line` and `line_cnt`=height. With `sp_on`=1 and `sp_first_mode`=0, `first_line`=0 and `line_cnt`=`sp_line`. With `sp_on`=0, `first_line`=0 and `line_cnt`=height.
- R10: `stride` equals width × bpp / 8. `color16` equals `tft` at 16 bpp and is 0 at other depths.
- R11: After reset, `en_active`, `pal_done`, `rd_req`, `dma_cond`, `bpp` and `frame_base` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Controller enable request |
| plm | input | 2 | Palette-load mode (1: no fetch, 2: data only) |
| tft | input | 1 | Selects 16-bit rather than 12-bit colour at 16 bpp |
| width_m1 | input | DW | Frame width minus one |
| height_m1 | input | DW | Frame height minus one |
| sp_on | input | 1 | Subpanel limit active |
| sp_first_mode | input | 1 | 1: `sp_line` is the first line; 0: it is the line count |
| sp_line | input | DW | Subpanel line number |
| dual | input | 1 | Ping-pong between two buffers |
| top0 | input | AW | Buffer 0 start address |
| bot0 | input | AW | Buffer 0 end address |
| top1 | input | AW | Buffer 1 start address |
| bot1 | input | AW | Buffer 1 end address |
| addr_ok | input | 4 | Validity of top0, bot0, top1, bot1 (bits 0..3) |
| dma_ie | input | 2 | Bit 0: frame interrupt enable; bit 1: address-error interrupt enable |
| frame_tick | input | 1 | Refresh request |
| rd_req | output | 1 | Palette word read request |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge |
| rd_depth | input | 3 | Bits 14:12 of the returned word |
| en_active | output | 1 | Controller effectively enabled |
| pal_done | output | 1 | Palette loaded since last enable |
| frame_done | output | 1 | One-cycle pulse: frame accepted |
| frame_base | output | AW | Pixel data start address |
| bpp | output | 5 | Bits per pixel of the last frame |
| color16 | output | 1 | 16-bit colour at 16 bpp |
| stride | output | DW+2 | Line stride in bytes |
| first_line | output | DW | First displayed line |
| line_cnt | output | DW+1 | Displayed line count |
| dma_cond | output | 3 | Sticky condition flags |
| dma_irq | output | 1 | One-cycle DMA interrupt pulse |
| sync_err | output | 1 | One-cycle oversize pulse |

## Verification
The bench sweeps every depth field under both header modes. A swapped depth mapping or a wrong 0x20/0x200 boundary would show up as the wrong base or stride. A mode-2 path that still reads memory, or that forgets the stored field, would show up as an extra read or as a stale depth. The fit check is probed exactly at size+2 and at size+3, and with bottom below top. An off-by-one comparison, or a subtraction that wraps, would accept or reject the wrong frame. The bench also checks that after a sync error the block stays off until enable toggles. Dual mode is exercised over several frames and across a re-enable: a buffer index that is not reset or not toggled sends frames to the wrong buffer. Enables with bad address flags are checked with the dual condition, so an ignored buffer-1 flag is caught, and with both interrupt-enable settings, so an ungated interrupt is caught.

// File: rtl/lcd_fetch_pkg.sv
package lcd_fetch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PAL  = 2'd1,
        ST_HDR  = 2'd2,
        ST_EVAL = 2'd3
    } fetch_st_e;

    localparam logic [1:0] PLM_NO_FETCH  = 2'd1;
    localparam logic [1:0] PLM_DATA_ONLY = 2'd2;

    localparam logic [9:0] HDR_SHORT = 10'h020;
    localparam logic [9:0] HDR_LONG  = 10'h200;

endpackage

// File: rtl/lcd_depth_dec.sv
module lcd_depth_dec
    import lcd_fetch_pkg::*;
(
    input  logic [2:0] code,
    input  logic       data_only,
    output logic [4:0] bpp,
    output logic [9:0] hdr_off,
    output logic       supported
);
    always_comb begin
        case (code)
            3'd1:    bpp = 5'd2;
            3'd2:    bpp = 5'd4;
            3'd3:    bpp = 5'd8;
            3'd0:    bpp = 5'd0;
            default: bpp = 5'd16;
        endcase
        supported = (code != 3'd0);
        if (data_only)
            hdr_off = '0;
        else if (code >= 3'd3)
            hdr_off = HDR_LONG;
        else
            hdr_off = HDR_SHORT;
    end
endmodule

// File: rtl/lcd_fit_chk.sv
module lcd_fit_chk #(
    parameter int AW = 32,
    parameter int DW = 10
) (
    input  logic [AW-1:0] top,
    input  logic [AW-1:0] bot,
    input  logic [DW:0]   width,
    input  logic [DW:0]   height,
    input  logic [4:0]    bpp,
    input  logic [9:0]    hdr_off,
    output logic          fits,
    output logic [DW+1:0] stride
);
    localparam int PW = 2 * (DW + 1) + 5;
    localparam int CW = ((PW > AW) ? PW : AW) + 2;

    logic [CW-1:0] prod;
    logic [CW-1:0] need;
    logic [CW-1:0] room;

    always_comb begin
        prod = CW'(width) * CW'(height) * CW'(bpp);
        need = CW'(hdr_off) + (prod >> 3);
        room = CW'(bot - top) + CW'(2);
        fits = (bot >= top) && (need <= room);
        case (bpp)
            5'd2:    stride = (DW+2)'(width >> 2);
            5'd4:    stride = (DW+2)'(width >> 1);
            5'd8:    stride = (DW+2)'(width);
            5'd16:   stride = {width, 1'b0};
            default: stride = '0;
        endcase
    end
endmodule

// File: rtl/lcd_line_sel.sv
module lcd_line_sel #(
    parameter int DW = 10
) (
    input  logic          sp_on,
    input  logic          sp_first_mode,
    input  logic [DW-1:0] sp_line,
    input  logic [DW:0]   height,
    output logic [DW-1:0] first_line,
    output logic [DW:0]   line_cnt
);
    always_comb begin
        first_line = (sp_on && sp_first_mode) ? sp_line : '0;
        line_cnt   = (sp_on && !sp_first_mode) ? {1'b0, sp_line} : height;
    end
endmodule

// File: rtl/lcd_fetch_seq.sv
module lcd_fetch_seq
    import lcd_fetch_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    plm,
    input  logic          tft,
    input  logic [DW-1:0] width_m1,
    input  logic [DW-1:0] height_m1,
    input  logic          sp_on,
    input  logic          sp_first_mode,
    input  logic [DW-1:0] sp_line,
    input  logic          dual,
    input  logic [AW-1:0] top0,
    input  logic [AW-1:0] bot0,
    input  logic [AW-1:0] top1,
    input  logic [AW-1:0] bot1,
    input  logic [3:0]    addr_ok,
    input  logic [1:0]    dma_ie,
    input  logic          frame_tick,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [2:0]    rd_depth,
    output logic          en_active,
    output logic          pal_done,
    output logic          frame_done,
    output logic [AW-1:0] frame_base,
    output logic [4:0]    bpp,
    output logic          color16,
    output logic [DW+1:0] stride,
    output logic [DW-1:0] first_line,
    output logic [DW:0]   line_cnt,
    output logic [2:0]    dma_cond,
    output logic          dma_irq,
    output logic          sync_err
);
    typedef struct packed {
        fetch_st_e     st;
        logic          en;
        logic          en_prev;
        logic          cur;
        logic          pal_done;
        logic [2:0]    code;
        logic          rd_req;
        logic [AW-1:0] rd_addr;
        logic          frame_done;
        logic          sync_err;
        logic          irq;
        logic [2:0]    cond;
        logic [AW-1:0] base;
        logic [4:0]    bpp;
        logic          color16;
        logic [DW+1:0] stride;
        logic [DW-1:0] first;
        logic [DW:0]   lines;
    } seq_t;

    seq_t q, d;

    logic [DW:0]   width_v, height_v;
    logic [AW-1:0] act_top, act_bot;
    logic [4:0]    dec_bpp;
    logic [9:0]    dec_off;
    logic          dec_ok;
    logic          fit_ok;
    logic [DW+1:0] fit_stride;
    logic [DW-1:0] sel_first;
    logic [DW:0]   sel_lines;
    logic          addr_good;

    assign width_v  = {1'b0, width_m1} + 1'b1;
    assign height_v = {1'b0, height_m1} + 1'b1;
    assign act_top  = q.cur ? top1 : top0;
    assign act_bot  = q.cur ? bot1 : bot0;

    lcd_depth_dec u_dec (
        .code      (q.code),
        .data_only (plm == PLM_DATA_ONLY),
        .bpp       (dec_bpp),
        .hdr_off   (dec_off),
        .supported (dec_ok)
    );

    lcd_fit_chk #(.AW(AW), .DW(DW)) u_fit (
        .top     (act_top),
        .bot     (act_bot),
        .width   (width_v),
        .height  (height_v),
        .bpp     (dec_bpp),
        .hdr_off (dec_off),
        .fits    (fit_ok),
        .stride  (fit_stride)
    );

    lcd_line_sel #(.DW(DW)) u_lines (
        .sp_on         (sp_on),
        .sp_first_mode (sp_first_mode),
        .sp_line       (sp_line),
        .height        (height_v),
        .first_line    (sel_first),
        .line_cnt      (sel_lines)
    );

    always_comb begin
        addr_good    = addr_ok[0] && addr_ok[1] && (!dual || (addr_ok[2] && addr_ok[3]));
        d            = q;
        d.frame_done = 1'b0;
        d.sync_err   = 1'b0;
        d.irq        = 1'b0;
        d.en_prev    = cfg_en;
        if (!cfg_en) begin
            d.en     = 1'b0;
            d.st     = ST_IDLE;
            d.rd_req = 1'b0;
        end else if (!q.en_prev) begin
            d.cur      = 1'b0;
            d.pal_done = 1'b0;
            if (!addr_good) begin
                d.cond[2] = 1'b1;
                d.irq     = dma_ie[1];
                d.en      = 1'b0;
                d.st      = ST_IDLE;
            end else begin
                d.en = 1'b1;
                if (plm != PLM_DATA_ONLY) begin
                    d.st      = ST_PAL;
                    d.rd_req  = 1'b1;
                    d.rd_addr = top0;
                end else begin
                    d.st = ST_IDLE;
                end
            end
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (q.en && frame_tick && plm != PLM_NO_FETCH) begin
                        if (plm == PLM_DATA_ONLY) begin
                            d.st = ST_EVAL;
                        end else begin
                            d.st      = ST_HDR;
                            d.rd_req  = 1'b1;
                            d.rd_addr = act_top;
                        end
                    end
                end
                ST_PAL: begin
                    if (rd_ack) begin
                        d.rd_req   = 1'b0;
                        d.code     = rd_depth;
                        d.pal_done = 1'b1;
                        d.st       = ST_IDLE;
                    end
                end
                ST_HDR: begin
                    if (rd_ack) begin
                        d.rd_req = 1'b0;
                        d.code   = rd_depth;
                        d.st     = ST_EVAL;
                    end
                end
                default: begin
                    d.st = ST_IDLE;
                    if (dec_ok) begin
                        if (!fit_ok) begin
                            d.sync_err = 1'b1;
                            d.en       = 1'b0;
                        end else begin
                            d.frame_done = 1'b1;
                            d.base       = act_top + AW'(dec_off);
                            d.bpp        = dec_bpp;
                            d.color16    = tft && (dec_bpp == 5'd16);
                            d.stride     = fit_stride;
                            d.first      = sel_first;
                            d.lines      = sel_lines;
                            d.irq        = dma_ie[0];
                            if (q.cur) d.cond[1] = 1'b1;
                            else       d.cond[0] = 1'b1;
                            if (dual) d.cur = ~q.cur;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req     = q.rd_req;
    assign rd_addr    = q.rd_addr;
    assign en_active  = q.en;
    assign pal_done   = q.pal_done;
    assign frame_done = q.frame_done;
    assign frame_base = q.base;
    assign bpp        = q.bpp;
    assign color16    = q.color16;
    assign stride     = q.stride;
    assign first_line = q.first;
    assign line_cnt   = q.lines;
    assign dma_cond   = q.cond;
    assign dma_irq    = q.irq;
    assign sync_err   = q.sync_err;
endmodule

// File: rtl/lcd_fetch_chk.sv
module lcd_fetch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic       rd_req,
    input logic       en_active,
    input logic       frame_done,
    input logic       sync_err,
    input logic [4:0] bpp,
    input logic [2:0] dma_cond
);
    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && sync_err)); // R4
    AST_SYNC_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !en_active); // R4
    AST_COND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_cond & $past(dma_cond)) == $past(dma_cond)); // R5
    AST_FRAME_SETS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (dma_cond[0] || dma_cond[1])); // R5
    AST_BPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (bpp == 5'd2 || bpp == 5'd4 || bpp == 5'd8 || bpp == 5'd16)); // R1
    AST_FRAME_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(en_active)); // R3
    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !rd_req); // R3
endmodule

bind lcd_fetch_seq lcd_fetch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .rd_req     (rd_req),
    .en_active  (en_active),
    .frame_done (frame_done),
    .sync_err   (sync_err),
    .bpp        (bpp),
    .dma_cond   (dma_cond)
);

// File: tb/lcd_fetch_seq_test.sv
module lcd_fetch_seq_test;
    localparam int AW = 32;
    localparam int DW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic [1:0] plm = 2'd0;
    logic tft = 1'b1;
    logic [DW-1:0] width_m1 = 10'd7;
    logic [DW-1:0] height_m1 = 10'd3;
    logic sp_on = 1'b0, sp_first_mode = 1'b0;
    logic [DW-1:0] sp_line = '0;
    logic dual = 1'b0;
    logic [AW-1:0] top0 = 32'h1000, bot0 = 32'h1400, top1 = 32'h3000, bot1 = 32'h3400;
    logic [3:0] addr_ok = 4'b0011;
    logic [1:0] dma_ie = 2'b11;
    logic frame_tick = 1'b0;
    logic rd_req;
    logic [AW-1:0] rd_addr;
    logic rd_ack = 1'b0;
    logic [2:0] rd_depth = '0;
    logic en_active, pal_done, frame_done, color16, dma_irq, sync_err;
    logic [AW-1:0] frame_base;
    logic [4:0] bpp;
    logic [DW+1:0] stride;
    logic [DW-1:0] first_line;
    logic [DW:0] line_cnt;
    logic [2:0] dma_cond;

    logic [15:0] word0, word1;
    int n_frame = 0, n_sync = 0, n_irq = 0, n_rd = 0;
    logic [AW-1:0] last_rd = '0;
    int d_frame, d_sync, d_irq, d_rd;
    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    lcd_fetch_seq #(.AW(AW), .DW(DW)) uut (.*);

    always @(negedge clk) begin
        if (frame_done) n_frame++;
        if (sync_err) n_sync++;
        if (dma_irq) n_irq++;
        if (rd_req && !rd_ack) begin
            rd_ack = 1'b1;
            rd_depth = (rd_addr == top1) ? word1[14:12] : word0[14:12];
            n_rd++;
            last_rd = rd_addr;
        end else begin
            rd_ack = 1'b0;
        end
    end

    function automatic logic [15:0] mkw(int c);
        return (16'h8A5C & ~16'h7000) | 16'((c & 7) << 12);
    endfunction

    function automatic int ebpp(int c);
        case (c)
            0: return 0;
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int eoff(int c, int p);
        if (p == 2) return 0;
        return (c >= 3) ? 512 : 32;
    endfunction

    task automatic chk(input string tag, input longint act, input longint expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic en_on();
        cfg_en = 1'b1;
        step(8);
    endtask

    task automatic en_off();
        cfg_en = 1'b0;
        step(2);
    endtask

    task automatic frame();
        int f0, s0, i0, r0;
        f0 = n_frame; s0 = n_sync; i0 = n_irq; r0 = n_rd;
        frame_tick = 1'b1;
        step(1);
        frame_tick = 1'b0;
        step(8);
        d_frame = n_frame - f0; d_sync = n_sync - s0;
        d_irq = n_irq - i0; d_rd = n_rd - r0;
    endtask

    initial begin
        int i0, r0;
        word0 = mkw(3);
        word1 = mkw(3);
        step(3);
        rst_n = 1'b1;
        step(1);
        // R11 reset state
        chk("R11 en_active", en_active, 0);
        chk("R11 pal_done", pal_done, 0);
        chk("R11 rd_req", rd_req, 0);
        chk("R11 dma_cond", dma_cond, 0);
        chk("R11 bpp", bpp, 0);
        chk("R11 frame_base", frame_base, 0);

        // R7 bad bottom-0 flag
        addr_ok = 4'b1101;
        i0 = n_irq;
        en_on();
        chk("R7 en stays low", en_active, 0);
        chk("R7 cond bit2", dma_cond[2], 1);
        chk("R7 irq with ie1", n_irq - i0, 1);
        chk("R7 no palette", pal_done, 0);
        en_off();
        // R7 dual needs buffer-1 flags, irq gated off
        dual = 1'b1; addr_ok = 4'b0111; dma_ie = 2'b01;
        i0 = n_irq;
        en_on();
        chk("R7 dual bad en", en_active, 0);
        chk("R7 irq gated", n_irq - i0, 0);
        en_off();
        dual = 1'b0; addr_ok = 4'b0011; dma_ie = 2'b11;

        // R8 data-only enable: no palette load
        plm = 2'd2;
        r0 = n_rd;
        en_on();
        chk("R8 en plm2", en_active, 1);
        chk("R8 pal_done plm2", pal_done, 0);
        chk("R8 no read plm2", n_rd - r0, 0);
        en_off();
        plm = 2'd0;
        word0 = mkw(2);
        r0 = n_rd;
        en_on();
        chk("R8 pal_done", pal_done, 1);
        chk("R8 read addr", last_rd, 32'h1000);
        chk("R8 one read", n_rd - r0, 1);

        // R3 no fetch in mode 1 or when disabled
        plm = 2'd1;
        frame();
        chk("R3 plm1 no read", d_rd, 0);
        chk("R3 plm1 no frame", d_frame, 0);
        plm = 2'd0;
        en_off();
        frame();
        chk("R3 off no read", d_rd, 0);
        chk("R3 off no frame", d_frame, 0);
        en_on();

        // R1 R2 R10 sweep of depth fields in both header modes
        for (int c = 0; c < 8; c++) begin
            word0 = mkw(c);
            plm = 2'd0;
            frame();
            chk("R2 hdr read", d_rd, 1);
            if (c == 0) begin
                chk("R1 skip frame", d_frame, 0);
                chk("R1 skip sync", d_sync, 0);
            end else begin
                chk("R1 frame", d_frame, 1);
                chk("R1 bpp", bpp, ebpp(c));
                chk("R2 base", frame_base, 32'h1000 + eoff(c, 0));
                chk("R10 stride", stride, 8 * ebpp(c) / 8);
                chk("R10 color16", color16, (ebpp(c) == 16) ? 1 : 0);
                chk("R5 irq", d_irq, 1);
            end
            plm = 2'd2;
            frame();
            chk("R2 mode2 no read", d_rd, 0);
            if (c == 0) begin
                chk("R1 mode2 skip", d_frame, 0);
            end else begin
                chk("R2 mode2 frame", d_frame, 1);
                chk("R2 mode2 base", frame_base, 32'h1000);
                chk("R2 mode2 bpp", bpp, ebpp(c));
            end
        end
        plm = 2'd0;

        // R10 12-bit colour when tft clear
        tft = 1'b0;
        word0 = mkw(4);
        frame();
        chk("R10 tft0 color16", color16, 0);
        tft = 1'b1;

        // R5 frame irq gating
        dma_ie = 2'b10;
        frame();
        chk("R5 frame gated", d_frame, 1);
        chk("R5 irq gated", d_irq, 0);
        chk("R5 cond0", dma_cond[0], 1);
        chk("R5 cond1 clear", dma_cond[1], 0);
        dma_ie = 2'b11;

        // R9 subpanel
        sp_on = 1'b1; sp_first_mode = 1'b1; sp_line = 10'd5;
        frame();
        chk("R9 first mode first", first_line, 5);
        chk("R9 first mode lines", line_cnt, 4);
        sp_first_mode = 1'b0; sp_line = 10'd3;
        frame();
        chk("R9 count mode first", first_line, 0);
        chk("R9 count mode lines", line_cnt, 3);
        sp_on = 1'b0;
        frame();
        chk("R9 off first", first_line, 0);
        chk("R9 off lines", line_cnt, 4);

        // R6 dual ping-pong
        en_off();
        dual = 1'b1; addr_ok = 4'hF;
        word0 = mkw(3); word1 = mkw(3);
        en_on();
        frame();
        chk("R6 frame1 base", frame_base, 32'h1200);
        frame();
        chk("R6 frame2 base", frame_base, 32'h3200);
        chk("R6 frame2 read", last_rd, 32'h3000);
        chk("R5 cond1 set", dma_cond[1], 1);
        frame();
        chk("R6 frame3 base", frame_base, 32'h1200);
        en_off();
        en_on();
        frame();
        chk("R6 reset to buf0", frame_base, 32'h1200);
        en_off();
        dual = 1'b0;
        en_on();
        frame();
        chk("R6 single stays", frame_base, 32'h1200);
        frame();
        chk("R6 single stays 2", frame_base, 32'h1200);

        // R4 fit boundary
        bot0 = 32'h1000 + 32'h21E;
        frame();
        chk("R4 exact fit frame", d_frame, 1);
        chk("R4 exact fit sync", d_sync, 0);
        bot0 = 32'h1000 + 32'h21D;
        frame();
        chk("R4 over frame", d_frame, 0);
        chk("R4 over sync", d_sync, 1);
        chk("R4 over disables", en_active, 0);
        frame();
        chk("R4 stays off", d_rd, 0);
        en_off();
        en_on();
        chk("R4 re-enable", en_active, 1);
        bot0 = 32'h0FFC;
        word0 = mkw(1);
        frame();
        chk("R4 bottom below top", d_sync, 1);
        chk("R4 bottom below top frame", d_frame, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule